// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Engine

This block copies a block of words between one peripheral and system memory so that the processor does not have to handle each word. The processor uses a small register port to program four things: a memory start address, a word count, a transfer direction and a bus-sharing policy. Setting the arm bit then starts the transfer. The engine asks for the system bus with a request/grant handshake. While it owns the bus it moves one word in each cycle where the peripheral signals that data is ready. On every word it steps the address up and the count down.

Three bus-sharing policies are available. In hold mode the engine keeps the bus from the first word to the last. In interleave mode it gives the bus back for a cycle after every word. In idle-only mode it moves a word only in cycles where the processor reports that the bus is free. When the last word is moved, the engine lets go of the bus and raises a level interrupt. The interrupt stays up until software acknowledges it.

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req, irq, mem_we, mem_re and dev_ack are low, and the status register (sel 3) reads 0.
- R2: Register selects are fixed. Sel 0 holds the address and sel 1 holds the count. Sel 2 is control: bit0 is the arm bit and always reads 0, bit1 is direction (0 = peripheral to memory, 1 = memory to peripheral), and bits 3:2 are the mode (0 = hold, 1 = interleave, 2 = idle-only, 3 = same as hold). Sel 3 is status: bit0 is done, bit1 is error, bit2 is busy. Writing a 1 to status bit0 clears done, and writing a 1 to status bit1 clears error.
- R3: Writing control with bit0 set while idle and with a nonzero count raises bus_req from the next cycle. No word is moved (dev_ack, mem_we and mem_re stay low) unless bus_grant is high.
- R4: A word is moved only in a cycle where dev_req is high. Each move pulses dev_ack for that cycle and drives mem_addr with the current address. At the clock edge ending that cycle, the address increments and the count decrements.
- R5: With direction 0, each move asserts mem_we and puts dev_rdata on mem_wdata. With direction 1, each move asserts mem_re and passes mem_rdata to dev_wdata.
- R6: In hold mode (and mode 3), bus_req stays high after every word except the last.
- R7: In interleave mode, bus_req is low in the cycle after every word except the last, and is high again in the cycle after that.
- R8: In idle-only mode, no word is moved in a cycle where bus_busy is high.
- R9: In the cycle after the last word, bus_req is low and irq and status done are high. irq stays high until status is written with bit0 set, or until a new transfer is armed.
- R10: While busy, writes to sel 0, 1 or 2 are ignored and set status error. A status write with bit1 set clears error.
- R11: Arming with a count of 0 sets done and irq in the next cycle and never raises bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_sel (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_busy | input | 1 | Processor is using the bus this cycle |
| mem_addr | output | ADDR_W | Memory address (zero when not granted) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data (same cycle) |
| dev_req | input | 1 | Peripheral is ready for a word |
| dev_ack | output | 1 | A word is moved this cycle |
| dev_rdata | input | DATA_W | Data from the peripheral |
| dev_wdata | output | DATA_W | Data to the peripheral |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The bench targets four corner cases. The first is the last word. A design that miscounts there moves one word too many or too few, which leaves the final address wrong and moves the memory contents by one position. The second is the interleave gap: a design that never drops its request after a word would let the bench see bus_req high in the cycle after a move. The third is a busy bus in idle-only mode and a withheld grant or data-ready signal: a design that ignores these would pulse dev_ack while bus_busy is held high, or while the grant or dev_req is low. The bench also writes the registers in the middle of a transfer, which would corrupt the final address or skip the error flag if the write were not blocked. It arms with a zero count, which would hang with bus_req raised if the count were not tested first. Finally it checks that the interrupt stays up until software clears it.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHARE = 2'd1,
    MODE_IDLE  = 2'd2,
    MODE_ALT   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int CTRL_ARM  = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_MODE = 2;
  localparam int STAT_DONE = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_BUSY = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic              finish,
  output logic              start_go,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              dir_q,
  output mode_e             mode_q,
  output logic              done_q,
  output logic              err_q
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic wr_addr, wr_count, wr_ctrl, wr_stat;
  logic addr_en, count_en, ctrl_en;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  count_d;
  logic done_d, err_d;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_addr  = reg_wr && (reg_sel == SEL_ADDR);
  assign wr_count = reg_wr && (reg_sel == SEL_COUNT);
  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);

  assign start_go = wr_ctrl && reg_wdata[CTRL_ARM] && !busy;
  assign addr_en  = step || (wr_addr && !busy);
  assign count_en = step || (wr_count && !busy);
  assign ctrl_en  = wr_ctrl && !busy;

  always_comb begin
    addr_d  = step ? addr_q + ADDR_ONE : reg_wdata[ADDR_W-1:0];
    count_d = step ? count_q - CNT_ONE : reg_wdata[CNT_W-1:0];
    if (finish)
      done_d = 1'b1;
    else if (start_go || (wr_stat && reg_wdata[STAT_DONE]))
      done_d = 1'b0;
    else
      done_d = done_q;
    if (busy && (wr_addr || wr_count || wr_ctrl))
      err_d = 1'b1;
    else if (wr_stat && reg_wdata[STAT_ERR])
      err_d = 1'b0;
    else
      err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
      mode_q  <= MODE_HOLD;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (count_en) count_q <= count_d;
      if (ctrl_en) begin
        dir_q  <= reg_wdata[CTRL_DIR];
        mode_q <= mode_e'(reg_wdata[CTRL_MODE +: 2]);
      end
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR:  reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_COUNT: reg_rdata[CNT_W-1:0]  = count_q;
      SEL_CTRL: begin
        reg_rdata[CTRL_DIR]         = dir_q;
        reg_rdata[CTRL_MODE +: 2]   = mode_q;
      end
      default: begin
        reg_rdata[STAT_DONE] = done_q;
        reg_rdata[STAT_ERR]  = err_q;
        reg_rdata[STAT_BUSY] = busy;
      end
    endcase
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_go,
  input  logic  count_zero,
  input  logic  count_last,
  input  mode_e mode,
  input  logic  bus_grant,
  input  logic  bus_busy,
  input  logic  dev_req,
  output logic  bus_req,
  output logic  busy,
  output logic  step,
  output logic  finish
);
  state_e st_q, st_d;
  logic   bus_free;

  assign bus_free = !((mode == MODE_IDLE) && bus_busy);
  assign step     = (st_q == ST_ACTIVE) && bus_grant && dev_req && bus_free;
  assign bus_req  = (st_q == ST_ACTIVE);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_go) begin
          if (count_zero) finish = 1'b1;
          else            st_d   = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (step) begin
          if (count_last) begin
            finish = 1'b1;
            st_d   = ST_IDLE;
          end else if (mode == MODE_SHARE) begin
            st_d = ST_GAP;
          end
        end
      end
      ST_GAP:  st_d = ST_ACTIVE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              bus_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              busy, step, finish, start_go;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q;
  logic              dir_q, done_q, err_q;
  mode_e             mode_q;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .step(step), .finish(finish), .start_go(start_go),
    .addr_q(addr_q), .count_q(count_q), .dir_q(dir_q), .mode_q(mode_q),
    .done_q(done_q), .err_q(err_q)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go),
    .count_zero(count_q == '0), .count_last(count_q == CNT_ONE),
    .mode(mode_q), .bus_grant(bus_grant), .bus_busy(bus_busy),
    .dev_req(dev_req), .bus_req(bus_req), .busy(busy),
    .step(step), .finish(finish)
  );

  assign mem_addr  = (bus_req && bus_grant) ? addr_q : '0;
  assign mem_we    = step && !dir_q;
  assign mem_re    = step && dir_q;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign dev_ack   = step;
  assign irq       = done_q;
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              bus_busy,
  input logic              dev_req,
  input logic              dev_ack,
  input logic              mem_we,
  input logic              mem_re,
  input logic              irq,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [1:0]        mode_q
);
  AST_MOVE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (bus_req && bus_grant)); // R3
  AST_MOVE_NEEDS_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (count_q == $past(count_q) - CNT_W'(1))); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> $onehot({mem_we, mem_re})); // R5
  AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && mode_q != 2'd1 && mode_q != 2'd2 && count_q != CNT_W'(1)) |=> bus_req); // R6
  AST_SHARE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && mode_q == 2'd1) |=> !bus_req); // R7
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && mode_q == 2'd2) |-> !bus_busy); // R8
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && count_q == CNT_W'(1)) |=> (!bus_req && irq)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R9
endmodule

bind dma_engine dma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .bus_req(bus_req),
  .bus_grant(bus_grant), .bus_busy(bus_busy), .dev_req(dev_req),
  .dev_ack(dev_ack), .mem_we(mem_we), .mem_re(mem_re), .irq(irq),
  .addr_q(addr_q), .count_q(count_q), .mode_q(mode_q)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int REG_W  = 32;

  typedef struct packed {
    logic       dir;
    logic [1:0] mode;
    logic [7:0] cnt;
    logic [7:0] start;
    logic       busy_pat;
    logic [7:0] base;
    logic [7:0] exp_end;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 2'd0, 8'd4, 8'd8,  1'b0, 8'h10, 8'd12},
    '{1'b1, 2'd0, 8'd3, 8'd0,  1'b0, 8'h00, 8'd3},
    '{1'b0, 2'd1, 8'd5, 8'd20, 1'b0, 8'h40, 8'd25},
    '{1'b1, 2'd1, 8'd2, 8'd30, 1'b0, 8'h00, 8'd32},
    '{1'b0, 2'd2, 8'd6, 8'd40, 1'b1, 8'h80, 8'd46},
    '{1'b1, 2'd2, 8'd1, 8'd50, 1'b1, 8'h00, 8'd51},
    '{1'b0, 2'd3, 8'd2, 8'd60, 1'b0, 8'hC0, 8'd62}
  };

  logic clk, rst_n;
  logic reg_wr;
  logic [1:0] reg_sel;
  logic [REG_W-1:0] reg_wdata, reg_rdata;
  logic bus_req, bus_grant, bus_busy;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_we, mem_re, dev_req, dev_ack, irq;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

  logic grant_en, dreq_en, busy_pat, busy_force, mem_init, dev_reset;
  logic [7:0] dev_base, dev_src;
  logic [3:0] cyc;
  logic [DATA_W-1:0] mem [0:63];
  logic [DATA_W-1:0] dev_log [0:15];
  int dev_n;
  int total, bad;

  dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_busy(bus_busy), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bus_grant <= 1'b0;
    else        bus_grant <= bus_req && grant_en;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 4'd1;

  assign dev_req   = dreq_en && (cyc % 3 != 2);
  assign bus_busy  = busy_force || (busy_pat && (cyc[1:0] != 2'd0));
  assign mem_rdata = mem[mem_addr[5:0]];
  assign dev_rdata = {{(DATA_W-8){1'b0}}, dev_src};

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 64; i++) mem[i] <= DATA_W'(i * 7 + 3);
    end else if (mem_we) begin
      mem[mem_addr[5:0]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (dev_reset) begin
      dev_src <= dev_base;
      dev_n   <= 0;
    end else if (dev_ack) begin
      dev_src <= dev_src + 8'd1;
      if (mem_re) dev_log[dev_n[3:0]] <= dev_wdata;
      dev_n <= dev_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [REG_W-1:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [REG_W-1:0] data);
    @(negedge clk);
    reg_sel = sel;
    #1 data = reg_rdata;
  endtask

  task automatic init_models(input logic [7:0] base);
    @(negedge clk);
    dev_base = base; mem_init = 1'b1; dev_reset = 1'b1;
    @(negedge clk);
    mem_init = 1'b0; dev_reset = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [REG_W-1:0] r;
    logic prev_ack;
    int exp_addr, moved, guard;
    init_models(v.base);
    busy_pat = v.busy_pat;
    wr(2'd0, REG_W'(v.start));
    wr(2'd1, REG_W'(v.cnt));
    wr(2'd2, REG_W'({v.mode, v.dir, 1'b1}));
    check("R3 bus_req after arm", bus_req, 1);
    exp_addr = v.start; moved = 0; prev_ack = 0; guard = 0;
    while (!irq && guard < 400) begin
      if (prev_ack && v.mode == 2'd1) check("R7 request dropped after word", bus_req, 0);
      if (prev_ack && (v.mode == 2'd0 || v.mode == 2'd3)) check("R6 request held", bus_req, 1);
      if (dev_ack) begin
        check("R3 move only with grant", bus_grant, 1);
        check("R4 move only with dev_req", dev_req, 1);
        check("R4 address per word", mem_addr, exp_addr);
        check("R5 write strobe", mem_we, !v.dir);
        check("R5 read strobe", mem_re, v.dir);
        if (v.mode == 2'd2) check("R8 move on idle bus", bus_busy, 0);
        exp_addr++; moved++;
      end
      prev_ack = dev_ack;
      guard++;
      @(negedge clk);
    end
    check("R9 irq after last word", irq, 1);
    check("R9 bus released", bus_req, 0);
    check("R4 words moved", moved, v.cnt);
    busy_pat = 1'b0;
    rd(2'd0, r); check("R4 final address", r, v.exp_end);
    rd(2'd1, r); check("R4 final count", r, 0);
    rd(2'd3, r); check("R9 status done", r, 1);
    for (int i = 0; i < v.cnt; i++) begin
      if (!v.dir) check("R5 peripheral to memory data", mem[v.start + i], v.base + i);
      else        check("R5 memory to peripheral data", dev_log[i], (v.start + i) * 7 + 3);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] r;
    total = 0; bad = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    grant_en = 1'b1; dreq_en = 1'b1; busy_pat = 1'b0; busy_force = 1'b0;
    mem_init = 1'b0; dev_reset = 1'b0; dev_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_req reset", bus_req, 0);
    check("R1 irq reset", irq, 0);
    check("R1 strobes reset", {mem_we, mem_re, dev_ack}, 0);
    rd(2'd3, r); check("R1 status reset", r, 0);

    wr(2'd2, 32'h0000_000A);
    rd(2'd2, r); check("R2 control readback", r, 32'hA);
    wr(2'd0, 32'h0012_3456);
    rd(2'd0, r); check("R2 address readback", r, 32'h0012_3456);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R11 zero count
    wr(2'd1, 0);
    wr(2'd2, 32'h1);
    check("R11 irq at once", irq, 1);
    check("R11 no bus request", bus_req, 0);
    repeat (4) @(negedge clk);
    check("R11 still no request", bus_req, 0);
    check("R9 irq held", irq, 1);
    wr(2'd3, 32'h1);
    check("R9 irq cleared", irq, 0);
    rd(2'd3, r); check("R2 status after clear", r, 0);

    // R3 and R10: grant withheld, writes while busy
    init_models(8'h20);
    grant_en = 1'b0;
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h1);
    for (int i = 0; i < 5; i++) begin
      check("R3 no move without grant", {dev_ack, mem_we, mem_re}, 0);
      @(negedge clk);
    end
    wr(2'd0, 32'd33);
    rd(2'd3, r); check("R10 error and busy", r, 32'h6);
    rd(2'd0, r); check("R10 address kept", r, 5);
    wr(2'd2, 32'h5);
    rd(2'd2, r); check("R10 control kept", r, 0);
    wr(2'd3, 32'h2);
    rd(2'd3, r); check("R10 error cleared", r, 32'h4);
    dreq_en = 1'b0; grant_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 no move without dev_req", dev_ack, 0);
    end
    dreq_en = 1'b1;
    for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
    check("R9 done after blocked writes", irq, 1);
    rd(2'd0, r); check("R10 final address", r, 8);

    // R8 bus held busy in idle-only mode
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h9);
    busy_force = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 no move while busy", dev_ack, 0);
    end
    busy_force = 1'b0;
    for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
    check("R8 completes when bus idle", irq, 1);
    rd(2'd0, r); check("R8 final address", r, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule